// File: doc/BRIEF.md
# Profiling Sample Filter Unit

This unit decides, for every completed profiling sample, whether the sample is kept or thrown away. Software programs a 64-bit control word through a plain write port and can read it back at any time. The word holds three filter enables (latency, operation type, event) and three operation-class selects (load, store, branch). Only those six bits are stored. Every other bit reads as zero, and writes to those bits have no effect.

A sample arrives as a one-cycle valid strobe with its details: class flags, total latency and an event bit vector. A minimum-latency threshold and an event selection mask come in on separate inputs. The unit applies the three enabled filters and combines their results with a logical AND. The type filter passes a sample that belongs to any selected class. The load class includes vector loads and atomics that return data. The store class includes vector stores and all atomics. The branch class includes exception returns.

Some enabled filters have a degenerate setting: a zero threshold, no class selected, or an empty event mask. In each of these cases the filter behaves as if it were switched off. The decision is registered and appears one clock after the strobe.

Top module: `sfu_top`

## Requirements
- R1: After a write, the read-back value equals the written word ANDed with the mask of the stored bits: bit 0 (event filter on), bit 1 (type filter on), bit 2 (latency filter on), bit 16 (branch select), bit 17 (load select), bit 18 (store select). All other bits read as zero.
- R2: With no write, the read-back value holds. A written pattern of the stored bits reads back unchanged.
- R3: `dec_valid` is high in the cycle after a cycle with `smp_valid` high, and low otherwise. `dec_record` is low whenever `dec_valid` is low.
- R4: A sample is recorded only if every enabled filter passes. With all filters off, every sample is recorded.
- R5: When type filtering is on and at least one class is selected, a sample is recorded only if one of its class flags matches a selected class. When type filtering is off, the class selects have no effect.
- R6: When latency filtering is on and the threshold is non-zero, a sample with latency below the threshold is dropped. A latency equal to the threshold passes.
- R7: When event filtering is on and the mask is non-zero, a sample passes only if its event vector has every bit of the mask set.
- R8: A zero threshold, no class selected, or an all-zero event mask makes the matching enabled filter act as disabled.
- R9: A sample presented in the same cycle as a control write is judged with the control value held before that write.
- R10: After reset, the read-back value is zero and `dec_valid` and `dec_record` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 64 | Control word write data |
| cfg_rd_data | output | 64 | Control word read-back |
| min_lat | input | LAT_W | Minimum-latency threshold |
| evt_sel | input | EVT_W | Event selection mask |
| smp_valid | input | 1 | Sample strobe |
| smp_is_load | input | 1 | Sample is a load-class operation |
| smp_is_store | input | 1 | Sample is a store-class operation |
| smp_is_branch | input | 1 | Sample is a branch-class operation |
| smp_latency | input | LAT_W | Sample total latency |
| smp_events | input | EVT_W | Sample event vector |
| dec_valid | output | 1 | Decision strobe, one cycle after the sample |
| dec_record | output | 1 | 1 = record, 0 = drop |

## Verification
A control write and a sample judgement can happen in the same clock. A new word lands in the register at the same edge that captures the decision. The bench provokes this by asserting `cfg_wr_en` and `smp_valid` in the same cycle. The new word would flip the outcome: type filtering selects loads only, a store sample arrives, and the write turns the type filter off. A drop decision shows that the old word was used. A follow-up store sample must then be recorded under the new word.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int CTRL_W  = 64;
    localparam int B_EVT   = 0;
    localparam int B_TYP   = 1;
    localparam int B_LAT   = 2;
    localparam int B_BR    = 16;
    localparam int B_LD    = 17;
    localparam int B_ST    = 18;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (64'd1 << B_EVT) | (64'd1 << B_TYP) | (64'd1 << B_LAT) |
        (64'd1 << B_BR)  | (64'd1 << B_LD)  | (64'd1 << B_ST);

    typedef struct packed {
        logic st_sel;
        logic ld_sel;
        logic br_sel;
        logic lat_on;
        logic typ_on;
        logic evt_on;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.st_sel = w[B_ST];
        c.ld_sel = w[B_LD];
        c.br_sel = w[B_BR];
        c.lat_on = w[B_LAT];
        c.typ_on = w[B_TYP];
        c.evt_on = w[B_EVT];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w        = '0;
        w[B_ST]  = c.st_sel;
        w[B_LD]  = c.ld_sel;
        w[B_BR]  = c.br_sel;
        w[B_LAT] = c.lat_on;
        w[B_TYP] = c.typ_on;
        w[B_EVT] = c.evt_on;
        return w;
    endfunction

endpackage

// File: rtl/sfu_ctrl_reg.sv
module sfu_ctrl_reg
    import sfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output ctrl_t             ctrl
);

    typedef struct packed {
        ctrl_t fields;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.fields = unpack_ctrl(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.fields;
    assign rd_data = pack_ctrl(st_q.fields);

    AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & CTRL_MASK)); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/sfu_filter_eval.sv
module sfu_filter_eval
    import sfu_pkg::*;
#(
    parameter int LAT_W = 16,
    parameter int EVT_W = 16
) (
    input  ctrl_t             ctrl,
    input  logic [LAT_W-1:0]  min_lat,
    input  logic [EVT_W-1:0]  evt_sel,
    input  logic              is_load,
    input  logic              is_store,
    input  logic              is_branch,
    input  logic [LAT_W-1:0]  latency,
    input  logic [EVT_W-1:0]  events,
    output logic              pass
);

    logic             any_class;
    logic             class_hit;
    logic             typ_ok;
    logic             lat_ok;
    logic             evt_ok;
    logic [EVT_W-1:0] bit_ok;

    // per-bit event coverage: a bit not in the mask never blocks
    for (genvar i = 0; i < EVT_W; i++) begin : g_evt
        assign bit_ok[i] = !evt_sel[i] || events[i];
    end

    always_comb begin
        any_class = ctrl.ld_sel || ctrl.st_sel || ctrl.br_sel;
        class_hit = (ctrl.ld_sel && is_load) ||
                    (ctrl.st_sel && is_store) ||
                    (ctrl.br_sel && is_branch);
        typ_ok    = !ctrl.typ_on || !any_class || class_hit;
        lat_ok    = !ctrl.lat_on || (min_lat == '0) || (latency >= min_lat);
        evt_ok    = !ctrl.evt_on || (evt_sel == '0) || (&bit_ok);
        pass      = typ_ok && lat_ok && evt_ok;
    end

endmodule

// File: rtl/sfu_decide_reg.sv
module sfu_decide_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic pass,
    output logic dec_valid,
    output logic dec_record
);

    typedef struct packed {
        logic vld;
        logic rec;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d.vld = smp_valid;
        st_d.rec = smp_valid && pass;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid  = st_q.vld;
    assign dec_record = st_q.rec;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> dec_valid); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !dec_valid); // R3

    AST_RECORD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_record); // R3

endmodule

// File: rtl/sfu_top.sv
module sfu_top
    import sfu_pkg::*;
#(
    parameter int LAT_W = 16,
    parameter int EVT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [63:0]       cfg_wr_data,
    output logic [63:0]       cfg_rd_data,
    input  logic [LAT_W-1:0]  min_lat,
    input  logic [EVT_W-1:0]  evt_sel,
    input  logic              smp_valid,
    input  logic              smp_is_load,
    input  logic              smp_is_store,
    input  logic              smp_is_branch,
    input  logic [LAT_W-1:0]  smp_latency,
    input  logic [EVT_W-1:0]  smp_events,
    output logic              dec_valid,
    output logic              dec_record
);

    ctrl_t ctrl;
    logic  pass;

    sfu_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .ctrl    (ctrl)
    );

    sfu_filter_eval #(
        .LAT_W (LAT_W),
        .EVT_W (EVT_W)
    ) u_eval (
        .ctrl      (ctrl),
        .min_lat   (min_lat),
        .evt_sel   (evt_sel),
        .is_load   (smp_is_load),
        .is_store  (smp_is_store),
        .is_branch (smp_is_branch),
        .latency   (smp_latency),
        .events    (smp_events),
        .pass      (pass)
    );

    sfu_decide_reg u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .pass       (pass),
        .dec_valid  (dec_valid),
        .dec_record (dec_record)
    );

    AST_ALL_OFF_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctrl.lat_on && !ctrl.typ_on && !ctrl.evt_on) |=> dec_record); // R4

    AST_LAT_BELOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ctrl.lat_on && min_lat != '0 && smp_latency < min_lat)
        |=> !dec_record); // R6

    AST_TYPE_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ctrl.typ_on && (ctrl.ld_sel || ctrl.st_sel || ctrl.br_sel) &&
         !(ctrl.ld_sel && smp_is_load) && !(ctrl.st_sel && smp_is_store) &&
         !(ctrl.br_sel && smp_is_branch)) |=> !dec_record); // R5

    AST_EVT_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ctrl.evt_on && evt_sel != '0 &&
         (smp_events & evt_sel) != evt_sel) |=> !dec_record); // R7

endmodule

// File: tb/sfu_top_tb_top.sv
module sfu_top_tb_top;

    localparam int LAT_W = 16;
    localparam int EVT_W = 16;
    localparam int NV    = 20;

    // control bits: evt on 0x1, type on 0x2, lat on 0x4, br 0x10000, ld 0x20000, st 0x40000
    typedef struct packed {
        logic [18:0] ctrl;
        logic [7:0]  mlat;
        logic [7:0]  sel;
        logic [2:0]  cls;   // {store, load, branch}
        logic [7:0]  lat;
        logic [7:0]  evt;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{19'h00000, 8'd0,  8'h00, 3'b010, 8'd3,  8'h00, 1'b1, 4'd4}, // R4 all off
        '{19'h20002, 8'd0,  8'h00, 3'b010, 8'd3,  8'h00, 1'b1, 4'd5}, // R5 load hit
        '{19'h20002, 8'd0,  8'h00, 3'b100, 8'd3,  8'h00, 1'b0, 4'd5}, // R5 store miss
        '{19'h60002, 8'd0,  8'h00, 3'b100, 8'd3,  8'h00, 1'b1, 4'd5}, // R5 ld|st store
        '{19'h10002, 8'd0,  8'h00, 3'b001, 8'd3,  8'h00, 1'b1, 4'd5}, // R5 branch
        '{19'h20002, 8'd0,  8'h00, 3'b000, 8'd3,  8'h00, 1'b0, 4'd5}, // R5 no flag
        '{19'h60000, 8'd0,  8'h00, 3'b001, 8'd3,  8'h00, 1'b1, 4'd5}, // R5 selects ignored
        '{19'h00002, 8'd0,  8'h00, 3'b100, 8'd3,  8'h00, 1'b1, 4'd8}, // R8 no class
        '{19'h00004, 8'd10, 8'h00, 3'b010, 8'd9,  8'h00, 1'b0, 4'd6}, // R6 below
        '{19'h00004, 8'd10, 8'h00, 3'b010, 8'd10, 8'h00, 1'b1, 4'd6}, // R6 equal
        '{19'h00004, 8'd0,  8'h00, 3'b010, 8'd0,  8'h00, 1'b1, 4'd8}, // R8 zero thr
        '{19'h00001, 8'd0,  8'h05, 3'b010, 8'd3,  8'h07, 1'b1, 4'd7}, // R7 superset
        '{19'h00001, 8'd0,  8'h05, 3'b010, 8'd3,  8'h04, 1'b0, 4'd7}, // R7 partial
        '{19'h00001, 8'd0,  8'h00, 3'b010, 8'd3,  8'h00, 1'b1, 4'd8}, // R8 empty mask
        '{19'h20007, 8'd5,  8'h01, 3'b010, 8'd6,  8'h01, 1'b1, 4'd4}, // R4 all pass
        '{19'h20007, 8'd5,  8'h01, 3'b010, 8'd6,  8'h00, 1'b0, 4'd4}, // R4 evt fails
        '{19'h20007, 8'd5,  8'h01, 3'b100, 8'd6,  8'h01, 1'b0, 4'd4}, // R4 type fails
        '{19'h20007, 8'd5,  8'h01, 3'b010, 8'd4,  8'h01, 1'b0, 4'd4}, // R4 lat fails
        '{19'h00000, 8'd10, 8'h0F, 3'b000, 8'd1,  8'h00, 1'b1, 4'd4}, // R4 lat/evt off
        '{19'h00006, 8'd0,  8'h00, 3'b000, 8'd0,  8'h00, 1'b1, 4'd8}  // R8 two degenerate
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [63:0]       cfg_wr_data = '0;
    logic [63:0]       cfg_rd_data;
    logic [LAT_W-1:0]  min_lat = '0;
    logic [EVT_W-1:0]  evt_sel = '0;
    logic              smp_valid = 1'b0;
    logic              smp_is_load = 1'b0;
    logic              smp_is_store = 1'b0;
    logic              smp_is_branch = 1'b0;
    logic [LAT_W-1:0]  smp_latency = '0;
    logic [EVT_W-1:0]  smp_events = '0;
    logic              dec_valid;
    logic              dec_record;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sfu_top #(.LAT_W(LAT_W), .EVT_W(EVT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_data   (cfg_wr_data),
        .cfg_rd_data   (cfg_rd_data),
        .min_lat       (min_lat),
        .evt_sel       (evt_sel),
        .smp_valid     (smp_valid),
        .smp_is_load   (smp_is_load),
        .smp_is_store  (smp_is_store),
        .smp_is_branch (smp_is_branch),
        .smp_latency   (smp_latency),
        .smp_events    (smp_events),
        .dec_valid     (dec_valid),
        .dec_record    (dec_record)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [63:0] w);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic set_sample(input logic [2:0] cls, input logic [7:0] lat,
                              input logic [7:0] evt);
        smp_valid     = 1'b1;
        smp_is_store  = cls[2];
        smp_is_load   = cls[1];
        smp_is_branch = cls[0];
        smp_latency   = LAT_W'(lat);
        smp_events    = EVT_W'(evt);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cfg_rd_data == 64'd0, "R10 rd", cfg_rd_data, 64'd0);
        chk(dec_valid == 1'b0 && dec_record == 1'b0, "R10 dec",
            {dec_valid, dec_record}, 0);

        // R1 reserved bits read zero
        write_ctrl('1);
        chk(cfg_rd_data == 64'h70007, "R1 mask", cfg_rd_data, 64'h70007);
        // R2 readback and hold
        write_ctrl(64'h20002);
        chk(cfg_rd_data == 64'h20002, "R2 readback", cfg_rd_data, 64'h20002);
        @(negedge clk);
        chk(cfg_rd_data == 64'h20002, "R2 hold", cfg_rd_data, 64'h20002);

        // table walk
        for (int i = 0; i < NV; i++) begin
            write_ctrl({45'd0, TBL[i].ctrl});
            min_lat = LAT_W'(TBL[i].mlat);
            evt_sel = EVT_W'(TBL[i].sel);
            set_sample(TBL[i].cls, TBL[i].lat, TBL[i].evt);
            @(negedge clk);
            smp_valid = 1'b0;
            chk(dec_valid == 1'b1, $sformatf("R3 vec%0d", i), dec_valid, 1);
            chk(dec_record == TBL[i].exp, $sformatf("R%0d vec%0d", TBL[i].req, i),
                dec_record, TBL[i].exp);
            @(negedge clk);
            chk(dec_valid == 1'b0 && dec_record == 1'b0, $sformatf("R3 idle%0d", i),
                {dec_valid, dec_record}, 0);
        end

        // R3 back-to-back samples, alternating outcome
        write_ctrl(64'h20002);
        set_sample(3'b010, 8'd1, 8'd0);
        @(negedge clk);
        chk(dec_valid && dec_record, "R3 b2b first", {dec_valid, dec_record}, 3);
        set_sample(3'b100, 8'd1, 8'd0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(dec_valid && !dec_record, "R3 b2b second", {dec_valid, dec_record}, 2);
        @(negedge clk);

        // R9 write and sample in the same cycle: old word judges
        cfg_wr_en   = 1'b1;
        cfg_wr_data = 64'h0;
        set_sample(3'b100, 8'd1, 8'd0);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(dec_valid && !dec_record, "R9 old word", {dec_valid, dec_record}, 2);
        chk(cfg_rd_data == 64'd0, "R9 new word", cfg_rd_data, 64'd0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(dec_valid && dec_record, "R9 next sample", {dec_valid, dec_record}, 3);
        @(negedge clk);

        // R10 reset clears a stored word
        write_ctrl(64'h7);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(cfg_rd_data == 64'd0, "R10 rereset", cfg_rd_data, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule